// File: doc/BRIEF.md
# Serial Receiver with Four-Character Flow Control

This block receives an asynchronous 8N1 serial character stream. It samples the line on a 16x oversampling tick and places each character in a three-entry receive queue. The shift register behind the queue can keep one further completed character. The host takes characters one at a time with a read strobe. Three flags report the receive state: a character is ready, the queue is full, and a character was lost.

The request-to-send output is active low. Two command codes drive it directly. When automatic mode is on, the receiver also pulls it inactive when the start bit of a new character is validated while the queue is already full. The sender then stops with four characters held: three in the queue and one in the shift slot. A fifth character that still arrives is dropped, and the sticky lost-character flag is set. Only a dedicated command clears that flag.

Top module: `uart_rx_rts`

## Requirements
- R1: After reset, rx_rdy_o, ffull_o and overrun_o are 0 and rts_no is 1.
- R2: A start bit is accepted only if rxd_i is still low on the 8th consecutive tick after it falls. A shorter low pulse produces no character.
- R3: Eight data bits are taken LSB first, one every 16 ticks at mid-bit, followed by one stop bit. The character appears on rd_data_o.
- R4: rx_rdy_o is 1 while the queue holds at least one character. A pulse on rd_i removes the oldest character, so characters come out in arrival order.
- R5: ffull_o is 1 exactly when the queue holds three characters. It clears after a read leaves fewer than three.
- R6: A character that completes while the queue is full is kept in the shift slot. It enters the queue as soon as a read frees an entry.
- R7: A character that completes while the queue is full and the shift slot is occupied is discarded, and overrun_o is set.
- R8: overrun_o stays set through reads and is cleared only by command code 4'b0100.
- R9: With cmd_valid_i high, command code 4'b1000 asserts RTS (rts_no = 0) and 4'b1001 negates it (rts_no = 1). Commands are ignored while cmd_valid_i is low.
- R10: With auto_rts_i = 1 and RTS asserted, rts_no goes to 1 once a start bit is validated while the queue is full. It returns to 0 once the queue is no longer full.
- R11: With auto_rts_i = 0, the queue state has no effect on rts_no.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | 16x bit-rate sampling enable |
| rxd_i | input | 1 | Serial data in, idle high |
| auto_rts_i | input | 1 | Enables automatic RTS negation |
| rd_i | input | 1 | Read strobe, pops the oldest character |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 4 | Command code |
| rd_data_o | output | 8 | Oldest queued character |
| rx_rdy_o | output | 1 | Queue not empty |
| ffull_o | output | 1 | Queue full |
| overrun_o | output | 1 | Sticky lost-character flag |
| rts_no | output | 1 | Request to send, active low |

## Verification
The bench ties the tick high, so one bit lasts 16 clock cycles. A character enters the queue two cycles after its stop-bit sample, so the bench checks received data only after the whole 160-cycle frame plus a margin. RTS negation follows the validated start bit by one register stage, and the bench samples it 12 cycles into the start bit. After a read, the queue count drops on the next edge and the shift-slot character moves in one edge later. For that reason the bench waits three cycles after a read before it checks ffull_o and rts_no, and samples every value on the falling edge.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OSR    = 16;
  localparam logic [3:0] CMD_CLR_OVR = 4'b0100;
  localparam logic [3:0] CMD_RTS_ON  = 4'b1000;
  localparam logic [3:0] CMD_RTS_OFF = 4'b1001;
  typedef enum logic {ST_IDLE, ST_FRAME} rx_state_e;
endpackage

// File: rtl/rx_sampler.sv
module rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned OS  = OSR
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rxd_i,
  output logic          start_o,
  output logic          done_o,
  output logic [DW-1:0] data_o
);
  localparam int unsigned CW = $clog2(OS);
  localparam int unsigned BW = $clog2(DW + 1);
  localparam logic [CW-1:0] MID  = CW'(OS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OS - 1);

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      start_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      start_o <= 1'b0;
      done_o  <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          ST_IDLE: begin
            if (rxd_i) cnt_q <= '0;
            else if (cnt_q == MID) begin
              state_q <= ST_FRAME;
              cnt_q   <= '0;
              bit_q   <= '0;
              start_o <= 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_FRAME: begin
            if (cnt_q == LAST) begin
              cnt_q <= '0;
              if (bit_q == BW'(DW)) begin
                state_q <= ST_IDLE;
                done_o  <= 1'b1;
              end else begin
                sh_q  <= {rxd_i, sh_q[DW-1:1]};
                bit_q <= bit_q + 1'b1;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign data_o = sh_q;
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned NW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [NW-1:0] cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == NW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rp_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + NW'(do_push) - NW'(do_pop);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (do_push && wp_q == PW'(i)) mem_q[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/rts_ctrl.sv
module rts_ctrl
  import uart_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [3:0] cmd_i,
  input  logic       auto_i,
  input  logic       start_i,
  input  logic       full_i,
  output logic       rts_no
);
  logic man_on_q, block_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      man_on_q <= 1'b0;
      block_q  <= 1'b0;
    end else begin
      if (cmd_valid_i && cmd_i == CMD_RTS_ON)  man_on_q <= 1'b1;
      if (cmd_valid_i && cmd_i == CMD_RTS_OFF) man_on_q <= 1'b0;
      if (!full_i)      block_q <= 1'b0;
      else if (start_i) block_q <= 1'b1;
    end
  end

  // output is a NAND of manual request and receiver-side readiness
  assign rts_no = ~(man_on_q & ~(auto_i & block_q));
endmodule

// File: rtl/uart_rx_rts.sv
module uart_rx_rts
  import uart_rx_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned DEPTH = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick16_i,
  input  logic          rxd_i,
  input  logic          auto_rts_i,
  input  logic          rd_i,
  input  logic          cmd_valid_i,
  input  logic [3:0]    cmd_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rx_rdy_o,
  output logic          ffull_o,
  output logic          overrun_o,
  output logic          rts_no
);
  logic          start_s, done_s, empty_s, full_s;
  logic [DW-1:0] char_s;
  logic          hold_v_q;
  logic [DW-1:0] hold_q;
  logic          push_s;
  logic [DW-1:0] push_d;
  logic          lose_s;

  rx_sampler #(.DW(DW), .OS(OSR)) u_smp (
    .clk_i, .rst_ni, .tick_i(tick16_i), .rxd_i,
    .start_o(start_s), .done_o(done_s), .data_o(char_s)
  );

  // shift slot drains first so arrival order is kept
  always_comb begin
    push_s = 1'b0;
    push_d = char_s;
    lose_s = 1'b0;
    if (hold_v_q && !full_s) begin
      push_s = 1'b1;
      push_d = hold_q;
    end else if (done_s && !hold_v_q && !full_s) begin
      push_s = 1'b1;
    end
    if (done_s && hold_v_q && full_s) lose_s = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q  <= 1'b0;
      hold_q    <= '0;
      overrun_o <= 1'b0;
    end else begin
      if (done_s && (hold_v_q || full_s)) begin
        if (!lose_s) begin
          hold_v_q <= 1'b1;
          hold_q   <= char_s;
        end
      end else if (hold_v_q && !full_s) begin
        hold_v_q <= 1'b0;
      end
      if (lose_s) overrun_o <= 1'b1;
      else if (cmd_valid_i && cmd_i == CMD_CLR_OVR) overrun_o <= 1'b0;
    end
  end

  rx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(push_s), .wdata_i(push_d), .pop_i(rd_i),
    .rdata_o(rd_data_o), .empty_o(empty_s), .full_o(full_s)
  );

  rts_ctrl u_rts (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_i, .auto_i(auto_rts_i),
    .start_i(start_s), .full_i(full_s), .rts_no
  );

  assign rx_rdy_o = !empty_s;
  assign ffull_o  = full_s;
endmodule

// File: rtl/uart_rx_rts_chk.sv
module uart_rx_rts_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       auto_rts_i,
  input logic       cmd_valid_i,
  input logic [3:0] cmd_i,
  input logic       rx_rdy_o,
  input logic       ffull_o,
  input logic       overrun_o,
  input logic       rts_no
);
  assert_full_has_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ffull_o |-> rx_rdy_o);
  assert_overrun_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !(cmd_valid_i && cmd_i == 4'b0100) |=> overrun_o);
  assert_overrun_needs_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(ffull_o));
  assert_rts_negate_cmd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_i == 4'b1001 |=> rts_no);
  assert_rts_manual_only_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_i == 4'b1000 && !auto_rts_i |=> !rts_no);
endmodule

bind uart_rx_rts uart_rx_rts_chk u_chk (
  .clk_i, .rst_ni, .auto_rts_i, .cmd_valid_i, .cmd_i,
  .rx_rdy_o, .ffull_o, .overrun_o, .rts_no
);

// File: tb/tb_uart_rx_rts.sv
module tb_uart_rx_rts;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rxd = 1'b1, auto_rts = 1'b0, rd = 1'b0, cmd_v = 1'b0;
  logic [3:0] cmd = '0;
  logic [7:0] rdata;
  logic rdy, ffull, ovr, rts_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_rx_rts dut (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(1'b1), .rxd_i(rxd),
    .auto_rts_i(auto_rts), .rd_i(rd), .cmd_valid_i(cmd_v), .cmd_i(cmd),
    .rd_data_o(rdata), .rx_rdy_o(rdy), .ffull_o(ffull), .overrun_o(ovr),
    .rts_no(rts_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic line_bits(input logic v, input int n);
    rxd = v;
    cyc(n);
  endtask

  task automatic start_only();
    line_bits(1'b0, 12);
  endtask

  task automatic rest_of_frame(input logic [7:0] b);
    line_bits(1'b0, 4);
    for (int i = 0; i < 8; i++) line_bits(b[i], 16);
    line_bits(1'b1, 18);
  endtask

  task automatic send(input logic [7:0] b);
    start_only();
    rest_of_frame(b);
  endtask

  task automatic command(input logic [3:0] c);
    cmd = c; cmd_v = 1'b1;
    cyc(1);
    cmd_v = 1'b0;
    cyc(1);
  endtask

  task automatic read_exp(input string req, input logic [7:0] exp);
    chk(req, {7'b0, rdy}, 8'h01);
    chk(req, rdata, exp);
    rd = 1'b1;
    cyc(1);
    rd = 1'b0;
    cyc(2);
  endtask

  task automatic t_reset();
    chk("R1 rdy", {7'b0, rdy}, 8'h00);
    chk("R1 ffull", {7'b0, ffull}, 8'h00);
    chk("R1 ovr", {7'b0, ovr}, 8'h00);
    chk("R1 rts", {7'b0, rts_n}, 8'h01);
  endtask

  task automatic t_single();
    send(8'hA5);
    read_exp("R3 A5", 8'hA5);
    send(8'h01);
    read_exp("R3 lsb", 8'h01);
    send(8'h80);
    read_exp("R3 msb", 8'h80);
    chk("R4 empty after read", {7'b0, rdy}, 8'h00);
  endtask

  task automatic t_glitch();
    line_bits(1'b0, 6);
    line_bits(1'b1, 200);
    chk("R2 short low ignored", {7'b0, rdy}, 8'h00);
  endtask

  task automatic t_manual_rts();
    cmd = 4'b1000; cyc(3);
    chk("R9 no strobe", {7'b0, rts_n}, 8'h01);
    command(4'b1000);
    chk("R9 assert", {7'b0, rts_n}, 8'h00);
    command(4'b1001);
    chk("R9 negate", {7'b0, rts_n}, 8'h01);
  endtask

  task automatic t_auto_flow();
    command(4'b1000);
    auto_rts = 1'b1;
    send(8'h11); send(8'h22);
    chk("R5 two not full", {7'b0, ffull}, 8'h00);
    send(8'h33);
    chk("R5 full", {7'b0, ffull}, 8'h01);
    chk("R10 still asserted", {7'b0, rts_n}, 8'h00);
    start_only();
    chk("R10 negated on start", {7'b0, rts_n}, 8'h01);
    rest_of_frame(8'h44);
    chk("R6 fourth no overrun", {7'b0, ovr}, 8'h00);
    send(8'h55);
    chk("R7 overrun set", {7'b0, ovr}, 8'h01);
    read_exp("R4 order", 8'h11);
    chk("R6 refilled", {7'b0, ffull}, 8'h01);
    chk("R10 reasserted", {7'b0, rts_n}, 8'h00);
    read_exp("R4 order", 8'h22);
    chk("R5 cleared", {7'b0, ffull}, 8'h00);
    read_exp("R4 order", 8'h33);
    read_exp("R6 held char", 8'h44);
    chk("R7 fifth lost", {7'b0, rdy}, 8'h00);
    chk("R8 sticky after reads", {7'b0, ovr}, 8'h01);
    command(4'b0100);
    chk("R8 cleared", {7'b0, ovr}, 8'h00);
  endtask

  task automatic t_no_auto();
    auto_rts = 1'b0;
    send(8'h61); send(8'h62); send(8'h63);
    start_only();
    chk("R11 ignored full", {7'b0, rts_n}, 8'h00);
    rest_of_frame(8'h64);
    read_exp("R11 drain", 8'h61);
    read_exp("R11 drain", 8'h62);
    read_exp("R11 drain", 8'h63);
    read_exp("R11 drain", 8'h64);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_single();
    t_glitch();
    t_manual_rts();
    t_auto_flow();
    t_no_auto();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule